// File: doc/BRIEF.md
# Mixed-Precision Bit-Slice Dispatcher

This block accepts one vector of fixed-point activations per transfer. Each element carries a flag that marks it as a 4-bit inlier or an 8-bit outlier. The block breaks the vector into bit-serial slices, where one slice is one bit position taken across every element. The lower four positions are shared by all elements, so they form dense slices and go to a dense stream that feeds an analog-style accumulator. The upper four positions exist only for outliers, so they form sparse slices and go to a separate stream that feeds a digital accumulator. In a sparse slice, every position that belongs to an inlier reads as zero.

Every slice is labelled sparse or dense by a programmable threshold. The threshold is a fraction with 12 fractional bits. The default value of 3924 equals about 95.8 % zeros, which is the point where the two accumulation styles cost about the same. The two output streams use independent valid/ready handshakes, so one path can stall while the other drains. A vector with no outliers still closes its sparse stream with a single end-of-vector marker beat. This lets the digital side count vectors without knowing the outlier pattern.

Top module: `bit_slice_dispatch`

## Requirements
- R1: A vector is taken on a clock edge where `vec_valid` and `vec_ready` are both high. `vec_ready` is high only while neither stream holds a pending slice. On the edge after a vector is taken, both `dn_valid` and `sp_valid` are high.
- R2: Each vector produces exactly four dense beats with `dn_pos` equal to 0, 1, 2 and 3, in that order. Bit i of `dn_bits` equals bit `dn_pos` of element i, and element i occupies `vec_data[8*i+7:8*i]`. `dn_last` is high only on the beat at position 3.
- R3: When at least one bit of `vec_outl` is set, the vector produces exactly four sparse beats with `sp_pos` equal to 4, 5, 6 and 7, in that order. Bit i of `sp_bits` equals bit `sp_pos` of element i ANDed with `vec_outl[i]`. `sp_last` is high only at position 7, and `sp_empty` is low.
- R4: The upper four bits of an element whose `vec_outl` bit is 0 have no effect: they never appear in `sp_bits`.
- R5: A vector with `vec_outl` all zero produces exactly one sparse beat. On that beat `sp_empty` is 1, `sp_last` is 1, `sp_pos` is 4 and `sp_bits` is all zero.
- R6: The label `dn_sparse` or `sp_sparse` is 1 exactly when Z*4096 >= T*N_POS. Here Z is the number of zero bits in the slice on the bus, and T is the threshold.
- R7: The threshold is taken from `thr_i` on the edge that accepts the vector. Later changes to `thr_i` do not alter the labels of that vector's slices.
- R8: While a stream's valid is high and its ready is low, every field of that stream holds its value. Each stream stalls independently of the other, and no slice is skipped or repeated.
- R9: After reset, `vec_ready` is 1 and both `dn_valid` and `sp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| thr_i | input | THR_W (12) | Sparsity threshold, fraction of zeros scaled by 4096 |
| vec_valid | input | 1 | Input vector valid |
| vec_ready | output | 1 | Block can accept a vector |
| vec_data | input | N_POS*HI_W (9216) | Packed elements, element i in bits 8i+7..8i |
| vec_outl | input | N_POS (1152) | Per-element outlier flag (1 = 8-bit element) |
| dn_valid | output | 1 | Dense slice valid |
| dn_ready | input | 1 | Dense consumer ready |
| dn_bits | output | N_POS | Dense slice, one bit per element |
| dn_pos | output | 3 | Bit position of the dense slice |
| dn_sparse | output | 1 | Dense slice meets the sparsity threshold |
| dn_last | output | 1 | Last dense slice of the vector |
| sp_valid | output | 1 | Sparse slice valid |
| sp_ready | input | 1 | Sparse consumer ready |
| sp_bits | output | N_POS | Sparse slice, nonzero only at outlier positions |
| sp_pos | output | 3 | Bit position of the sparse slice |
| sp_sparse | output | 1 | Sparse slice meets the sparsity threshold |
| sp_last | output | 1 | Last sparse beat of the vector (end-of-vector marker) |
| sp_empty | output | 1 | Beat is a marker only; the vector had no outliers |

## Verification
The bench aims at four corner cases.

The first is the label boundary. With the default threshold, 48 ones in a slice must be labelled sparse and 49 ones must be labelled dense. An off-by-one comparison or a rounded ratio flips one of these two labels.

The second is inliers with their upper bits set. A design that forgets the outlier mask leaks those bits into the sparse slices.

The third is a vector with no outliers. A design that handles it wrongly either emits four empty sparse beats or emits none, and the consumer then loses count of vectors.

The fourth covers the threshold changing and ready held low while a vector is in flight. These expose a design that labels from the live threshold, drops or repeats a stalled beat, or lets one stalled stream hold up the other.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

  // Sparsity decision: zero count scaled by 2^frac_bits against thr * total.
  function automatic logic meets_sparse(input longint unsigned zeros,
                                        input longint unsigned total,
                                        input longint unsigned thr,
                                        input int unsigned frac_bits);
    return (zeros << frac_bits) >= (thr * total);
  endfunction

  // Number of positions needed to represent a bit index below width.
  function automatic int unsigned pos_width(input int unsigned width);
    return (width <= 2) ? 1 : $clog2(width);
  endfunction

endpackage

// File: rtl/bsd_plane_store.sv
module bsd_plane_store #(
  parameter int unsigned N_POS = 1152,
  parameter int unsigned HI_W  = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load,
  input  logic [N_POS*HI_W-1:0]           data_i,
  input  logic [N_POS-1:0]                outl_i,
  output logic [HI_W-1:0][N_POS-1:0]      planes_o,
  output logic [N_POS-1:0]                mask_o
);

  // Transpose element-major input into bit-plane storage at capture time.
  for (genvar b = 0; b < HI_W; b++) begin : g_plane
    for (genvar i = 0; i < N_POS; i++) begin : g_elem
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    planes_o[b][i] <= 1'b0;
        else if (load) planes_o[b][i] <= data_i[i*HI_W + b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_o <= '0;
    else if (load) mask_o <= outl_i;
  end

endmodule

// File: rtl/bsd_lane.sv
module bsd_lane #(
  parameter int unsigned FIRST = 0,
  parameter int unsigned LAST  = 3,
  parameter int unsigned PW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          marker_only,
  input  logic          ready,
  output logic          valid,
  output logic [PW-1:0] pos,
  output logic          last,
  output logic          marker
);

  localparam logic [PW-1:0] FIRST_P = PW'(FIRST);
  localparam logic [PW-1:0] LAST_P  = PW'(LAST);
  localparam logic [PW-1:0] SPAN_P  = PW'(LAST - FIRST);

  logic          busy_q;
  logic [PW-1:0] pos_q;
  logic          mark_q;
  logic          beat_done;

  assign valid     = busy_q;
  assign pos       = pos_q;
  assign marker    = mark_q;
  assign last      = mark_q || (pos_q == LAST_P);
  assign beat_done = busy_q && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= FIRST_P;
      mark_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      pos_q  <= FIRST_P;
      mark_q <= marker_only;
    end else if (beat_done) begin
      if (last) begin
        busy_q <= 1'b0;
        mark_q <= 1'b0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  // R8: a stalled beat keeps its position and kind
  assert_lane_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(pos_q) && $stable(mark_q));

  // R2/R3: positions advance by one per accepted non-final beat
  assert_lane_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready && !last |=> valid && (pos_q == $past(pos_q) + 1'b1));

  // R2/R3: position stays within the lane's window
  assert_lane_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((pos_q - FIRST_P) <= SPAN_P));

  // R5: a marker beat is always the final beat
  assert_lane_marker_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid && mark_q |-> last && (pos_q == FIRST_P));

endmodule

// File: rtl/bsd_judge.sv
module bsd_judge #(
  parameter int unsigned N_POS = 1152,
  parameter int unsigned THR_W = 12
) (
  input  logic [N_POS-1:0] slice_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             sparse_o
);
  import bsd_pkg::*;

  localparam int unsigned CW = $clog2(N_POS + 1);

  logic [CW-1:0] ones;
  logic [CW-1:0] zeros;

  always_comb begin
    ones = '0;
    for (int i = 0; i < N_POS; i++) ones = ones + CW'(slice_i[i]);
  end

  assign zeros    = CW'(N_POS) - ones;
  assign sparse_o = meets_sparse(64'(zeros), 64'(N_POS), 64'(thr_i), THR_W);

endmodule

// File: rtl/bit_slice_dispatch.sv
module bit_slice_dispatch
  import bsd_pkg::*;
#(
  parameter int unsigned N_POS = 1152,
  parameter int unsigned LO_W  = 4,
  parameter int unsigned HI_W  = 8,
  parameter int unsigned THR_W = 12,
  localparam int unsigned PW   = pos_width(HI_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [THR_W-1:0]        thr_i,
  input  logic                    vec_valid,
  output logic                    vec_ready,
  input  logic [N_POS*HI_W-1:0]   vec_data,
  input  logic [N_POS-1:0]        vec_outl,
  output logic                    dn_valid,
  input  logic                    dn_ready,
  output logic [N_POS-1:0]        dn_bits,
  output logic [PW-1:0]           dn_pos,
  output logic                    dn_sparse,
  output logic                    dn_last,
  output logic                    sp_valid,
  input  logic                    sp_ready,
  output logic [N_POS-1:0]        sp_bits,
  output logic [PW-1:0]           sp_pos,
  output logic                    sp_sparse,
  output logic                    sp_last,
  output logic                    sp_empty
);

  logic                       accept;
  logic                       no_outl;
  logic [THR_W-1:0]           thr_q;
  logic [HI_W-1:0][N_POS-1:0] planes;
  logic [N_POS-1:0]           mask_q;
  logic                       dn_marker;

  assign vec_ready = !dn_valid && !sp_valid;
  assign accept    = vec_valid && vec_ready;
  assign no_outl   = ~|vec_outl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= '0;
    else if (accept) thr_q <= thr_i;
  end

  bsd_plane_store #(.N_POS(N_POS), .HI_W(HI_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .data_i(vec_data), .outl_i(vec_outl),
    .planes_o(planes), .mask_o(mask_q)
  );

  bsd_lane #(.FIRST(0), .LAST(LO_W - 1), .PW(PW)) u_dense_lane (
    .clk(clk), .rst_n(rst_n), .start(accept), .marker_only(1'b0),
    .ready(dn_ready), .valid(dn_valid), .pos(dn_pos),
    .last(dn_last), .marker(dn_marker)
  );

  bsd_lane #(.FIRST(LO_W), .LAST(HI_W - 1), .PW(PW)) u_sparse_lane (
    .clk(clk), .rst_n(rst_n), .start(accept), .marker_only(no_outl),
    .ready(sp_ready), .valid(sp_valid), .pos(sp_pos),
    .last(sp_last), .marker(sp_empty)
  );

  assign dn_bits = planes[dn_pos];
  assign sp_bits = sp_empty ? '0 : (planes[sp_pos] & mask_q);

  bsd_judge #(.N_POS(N_POS), .THR_W(THR_W)) u_dense_judge (
    .slice_i(dn_bits), .thr_i(thr_q), .sparse_o(dn_sparse)
  );

  bsd_judge #(.N_POS(N_POS), .THR_W(THR_W)) u_sparse_judge (
    .slice_i(sp_bits), .thr_i(thr_q), .sparse_o(sp_sparse)
  );

  // R1: an accepted vector opens both streams on the next edge
  assert_accept_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> dn_valid && sp_valid);

  // R1: no vector is taken while either stream still holds a slice
  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid || sp_valid) |-> !accept);

  // R5: marker beat carries no data
  assert_marker_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sp_valid && sp_empty |-> (sp_bits == '0) && sp_last);

  // R8: stalled dense data and label hold
  assert_dense_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> $stable(dn_bits) && $stable(dn_sparse) && $stable(dn_last));

  // R8: stalled sparse data and label hold
  assert_sparse_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_valid && !sp_ready |=> $stable(sp_bits) && $stable(sp_sparse) && $stable(sp_empty));

  // R7: captured threshold does not move while slices are pending
  assert_thr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid || sp_valid) && !accept |=> $stable(thr_q));

  // R4: sparse beats never carry inlier bits
  assert_mask_respected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sp_valid |-> ((sp_bits & ~mask_q) == '0));

endmodule

// File: tb/bit_slice_dispatch_tb.sv
module bit_slice_dispatch_tb;
  localparam int N  = 1152;
  localparam int TW = 12;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] thr_i = 12'd3924;
  logic vec_valid = 1'b0;
  logic vec_ready;
  logic [N*8-1:0] vec_data = '0;
  logic [N-1:0] vec_outl = '0;
  logic dn_valid, dn_ready = 1'b0, dn_sparse, dn_last;
  logic [N-1:0] dn_bits;
  logic [PW-1:0] dn_pos;
  logic sp_valid, sp_ready = 1'b0, sp_sparse, sp_last, sp_empty;
  logic [N-1:0] sp_bits;
  logic [PW-1:0] sp_pos;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  logic [7:0] tv [N];
  logic       to [N];
  int         thr_cap;

  always #5 clk = ~clk;

  bit_slice_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .thr_i(thr_i),
    .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_data(vec_data), .vec_outl(vec_outl),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_bits(dn_bits),
    .dn_pos(dn_pos), .dn_sparse(dn_sparse), .dn_last(dn_last),
    .sp_valid(sp_valid), .sp_ready(sp_ready), .sp_bits(sp_bits),
    .sp_pos(sp_pos), .sp_sparse(sp_sparse), .sp_last(sp_last),
    .sp_empty(sp_empty)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL R8 watchdog expired: actual=hung expected=drained");
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ones_of(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic logic any_outlier();
    for (int i = 0; i < N; i++) if (to[i]) return 1'b1;
    return 1'b0;
  endfunction

  // Expected slice from the stored stimulus; sparse slices keep outliers only.
  function automatic logic [N-1:0] ref_slice(input int bitpos, input bit sparse_path);
    logic [N-1:0] s;
    for (int i = 0; i < N; i++)
      s[i] = sparse_path ? (to[i] & tv[i][bitpos]) : tv[i][bitpos];
    return s;
  endfunction

  // Label rule: zero fraction at or above thr/4096.
  function automatic logic ref_label(input logic [N-1:0] s, input int thr);
    longint z = longint'(N - ones_of(s));
    return (z * 4096) >= (longint'(thr) * N);
  endfunction

  task automatic load_bus();
    for (int i = 0; i < N; i++) begin
      vec_data[8*i +: 8] = tv[i];
      vec_outl[i] = to[i];
    end
  endtask

  task automatic put_vector(input int thr_now, input int thr_after);
    load_bus();
    @(negedge clk);
    thr_i = TW'(thr_now);
    vec_valid = 1'b1;
    forever begin
      if (vec_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    thr_cap = thr_now;
    vec_valid = 1'b0;
    thr_i = TW'(thr_after);
  endtask

  // Drain one stream, sampling at negedges; the following posedge takes the beat.
  task automatic collect(input bit sparse_path, input int pct, input int delay);
    int beats;
    int k = 0;
    bit stalled = 0;
    logic [N-1:0] hb;
    logic [PW-1:0] hp;
    logic hs, hl;
    logic v, l, s, e;
    logic [N-1:0] b;
    logic [PW-1:0] p;
    bit marker = sparse_path && !any_outlier();
    beats = marker ? 1 : 4;
    repeat (delay) @(negedge clk);
    while (k < beats) begin
      @(negedge clk);
      v = sparse_path ? sp_valid : dn_valid;
      b = sparse_path ? sp_bits : dn_bits;
      p = sparse_path ? sp_pos : dn_pos;
      s = sparse_path ? sp_sparse : dn_sparse;
      l = sparse_path ? sp_last : dn_last;
      e = sparse_path ? sp_empty : 1'b0;
      if (!v) begin
        check(1'b0, "R8", "stream valid dropped mid-vector", 0, 1);
        if (sparse_path) sp_ready = 1'b0; else dn_ready = 1'b0;
        return;
      end
      if (stalled) begin
        check(b == hb && p == hp && s == hs && l == hl, "R8",
              "fields held while stalled", longint'(p), longint'(hp));
        stalled = 0;
      end
      if (($urandom % 100) < pct) begin
        if (sparse_path) sp_ready = 1'b1; else dn_ready = 1'b1;
        if (marker) begin
          check(e && l && p == 3'd4 && b == '0, "R5", "marker beat fields",
                longint'({e, l, p}), longint'({1'b1, 1'b1, 3'd4}));
          check(s == ref_label(b, thr_cap), "R6", "marker label",
                longint'(s), longint'(ref_label(b, thr_cap)));
        end else begin
          int ep = sparse_path ? 4 + k : k;
          logic [N-1:0] eb = ref_slice(ep, sparse_path);
          check(p == PW'(ep), sparse_path ? "R3" : "R2", "slice position",
                longint'(p), longint'(ep));
          check(b == eb, sparse_path ? "R3/R4" : "R2", "slice bits (ones count)",
                longint'(ones_of(b)), longint'(ones_of(eb)));
          check(l == (k == 3) && !e, sparse_path ? "R3" : "R2", "last/empty flags",
                longint'({l, e}), longint'({(k == 3), 1'b0}));
          check(s == ref_label(eb, thr_cap), "R6/R7", "slice label",
                longint'(s), longint'(ref_label(eb, thr_cap)));
        end
        k++;
      end else begin
        if (sparse_path) sp_ready = 1'b0; else dn_ready = 1'b0;
        stalled = 1; hb = b; hp = p; hs = s; hl = l;
      end
    end
    @(negedge clk);
    if (sparse_path) sp_ready = 1'b0; else dn_ready = 1'b0;
    check(!(sparse_path ? sp_valid : dn_valid), sparse_path ? "R3" : "R2",
          "no extra beat after last", longint'(sparse_path ? sp_valid : dn_valid), 0);
  endtask

  task automatic run_vector(input int thr_now, input int thr_after,
                            input int pct_d, input int pct_s);
    fork
      put_vector(thr_now, thr_after);
      begin @(posedge clk iff (vec_valid && vec_ready)); collect(1'b0, pct_d, 0); end
      begin @(posedge clk iff (vec_valid && vec_ready)); collect(1'b1, pct_s, 0); end
    join
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R9: reset state
    check(vec_ready && !dn_valid && !sp_valid, "R9", "reset outputs",
          longint'({vec_ready, dn_valid, sp_valid}), longint'(3'b100));
    rst_n = 1'b1;
    @(negedge clk);
    check(vec_ready && !dn_valid && !sp_valid, "R9", "idle after reset",
          longint'({vec_ready, dn_valid, sp_valid}), longint'(3'b100));

    // R5/R4: no outliers, inlier upper bits random and ignored
    for (int i = 0; i < N; i++) begin tv[i] = 8'($urandom); to[i] = 1'b0; end
    run_vector(3924, 3924, 70, 70);

    // R2/R3: all outliers, all ones
    for (int i = 0; i < N; i++) begin tv[i] = 8'hFF; to[i] = 1'b1; end
    run_vector(3924, 3924, 100, 100);

    // R6/R7/R4: 48 ones vs 49 ones at the label boundary; threshold changed in flight
    for (int i = 0; i < N; i++) begin
      to[i] = (i < 49);
      tv[i] = to[i] ? ((i < 48) ? 8'h33 : 8'h22) : {4'($urandom), 4'h0};
      if (i < 48) tv[i][0] = 1'b1;
      if (i < 49) tv[i][1] = 1'b1;
    end
    check(ref_label(ref_slice(4, 1), 3924) == 1'b1, "R6", "bench boundary 48 ones sparse", 1, 1);
    check(ref_label(ref_slice(5, 1), 3924) == 1'b0, "R6", "bench boundary 49 ones dense", 0, 0);
    run_vector(3924, 0, 60, 60);

    // R8: sparse stream held off while dense drains; vec_ready must stay low
    for (int i = 0; i < N; i++) begin tv[i] = 8'($urandom); to[i] = (i % 7 == 0); end
    fork
      put_vector(3000, 3000);
      begin
        @(posedge clk iff (vec_valid && vec_ready));
        collect(1'b0, 100, 0);
        check(sp_valid && !vec_ready, "R8/R1", "sparse pending, intake closed",
              longint'({sp_valid, vec_ready}), longint'(2'b10));
      end
      begin @(posedge clk iff (vec_valid && vec_ready)); collect(1'b1, 50, 12); end
    join

    // Random vectors with sparse outliers
    for (int n = 0; n < 30; n++) begin
      int rate = 1 + int'($urandom % 8);
      for (int i = 0; i < N; i++) begin
        to[i] = (($urandom % 100) < rate);
        tv[i] = to[i] ? 8'($urandom) : {4'($urandom), 4'($urandom)};
      end
      if (n % 5 == 0) for (int i = 0; i < N; i++) to[i] = 1'b0;
      run_vector(int'($urandom % 4096), int'($urandom % 4096),
                 30 + int'($urandom % 71), 30 + int'($urandom % 71));
    end

    summary();
    $finish;
  end
endmodule